// File: doc/BRIEF.md
# 2B+D Serial Frame Formatter

This block carries basic-rate data over a five-wire serial port. The data is two 64 kbit/s bearer channels (B1, B2) and one 16 kbit/s signalling channel (D). On the serial-input wire it gathers the bits meant for the line into parallel B1, B2 and D fields, then reports each completed frame with a one-cycle strobe. On the serial-output wire it sends parallel B1, B2 and D fields that were received from the line. Each direction has its own frame-sync input. The two directions share one bit clock. The block samples that bit clock, and both frame syncs, on its fast system clock and works out bit edges from them.

A two-bit layout selector chooses one of three fixed bit layouts:
- Layout A: straight 18-bit layout.
- Layout B: 19-bit layout that splits D around B2 and skips one bit.
- Layout C: 26-bit layout at half the bit rate, with an 8-bit gap before D.

A timing bit selects the frame-sync mode:
- Non-delayed: the sync edge marks the first bit.
- Delayed: the sync is seen one half clock ahead of the first bit.

Some layout/timing pairs are forbidden. When a forbidden pair is selected, the block raises an error and keeps the port quiet. A D-port flag removes both D bits from the serial port, so that the D channel can be carried elsewhere.

The serial output is meant for a tri-state pad. `ser_oe` enables the pad only during assigned bits; elsewhere the pin floats. While `ser_oe` is low, `ser_out` is held at 0.

Top module: `bri_port`

## Requirements
- R1: Layout A (code 0) puts B1 at frame bits 0-7, B2 at bits 8-15 and D at bits 16-17. Bits from 18 onward are unassigned. B bytes travel MSB first; D travels bit 1 first.
- R2: Layout B (code 1) puts B1 at bits 0-7, D bit 1 at bit 8, nothing at bit 9, B2 at bits 10-17 and D bit 0 at bit 18.
- R3: Layout C (code 2) puts B1 at bits 0-7, B2 at bits 8-15, nothing at bits 16-23 and D (bit 1 first) at bits 24-25. Each bit lasts two bit-clock periods. The output changes at the first rising edge of a bit, and the input is sampled at the falling edge 1.5 periods later.
- R4: With `cfg_delayed`=0, the first frame bit begins at the bit-clock rising edge where the frame sync is first seen high.
- R5: With `cfg_delayed`=1, the frame sync must be seen high at a falling edge, and the first frame bit begins at the next rising edge.
- R6: `cfg_err` is high for layout B without delayed timing, for layout C with delayed timing, and for layout code 3. While it is high, `ser_oe` stays low and no strobe is issued.
- R7: `ser_oe` is high only during assigned bits, and changes only on rising bit-clock edges. In layouts A and B, input bits are sampled on falling edges.
- R8: With `cfg_dport_en`=1, the D bits are neither driven nor captured, and `line_tx_d` reads 0.
- R9: After the frame's final layout bit is sampled, `line_tx_valid` pulses for exactly one system cycle, together with the captured bytes.
- R10: The transmit fields are taken at the first bit of the output frame. Changing them later in the frame does not affect that frame.
- R11: After reset, `ser_oe`, `ser_out`, `line_tx_valid` and the captured fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial bit clock, synchronous to clk |
| fs_tx | input | 1 | Frame sync for the serial-input direction |
| fs_rx | input | 1 | Frame sync for the serial-output direction |
| ser_in | input | 1 | Serial data toward the line |
| ser_out | output | 1 | Serial data from the line (0 when not driven) |
| ser_oe | output | 1 | Pad enable for ser_out |
| cfg_layout | input | 2 | Layout select: 0=A, 1=B, 2=C, 3=invalid |
| cfg_delayed | input | 1 | 1 = delayed frame-sync timing |
| cfg_dport_en | input | 1 | 1 = D bits removed from the serial port |
| line_rx_b1 | input | 8 | B1 byte to send on ser_out |
| line_rx_b2 | input | 8 | B2 byte to send on ser_out |
| line_rx_d | input | 2 | D bits to send on ser_out |
| line_tx_b1 | output | 8 | Captured B1 byte |
| line_tx_b2 | output | 8 | Captured B2 byte |
| line_tx_d | output | 2 | Captured D bits |
| line_tx_valid | output | 1 | One-cycle strobe for a completed frame |
| cfg_err | output | 1 | Illegal layout/timing combination |

## Verification
A bit counter that has drifted shows up within one bit period on `ser_oe` or `ser_out`. The wrong data bit is driven, or the pad is enabled in an unassigned position, such as the skipped bit of layout B or the gap of layout C. A wrong half-rate phase or a wrong sampling edge corrupts a captured byte. The strobe then reports a wrong field when the frame completes, or comes early, late or twice. A stale transmit hold register gives wrong bits after the mid-frame change of the parallel inputs.

// File: rtl/bri_pkg.sv
package bri_pkg;

    localparam int B_W   = 8;
    localparam int D_W   = 2;
    localparam int IDX_W = 5;
    localparam int POS_W = $clog2(B_W);

    localparam logic [1:0] LAYOUT_A = 2'd0;
    localparam logic [1:0] LAYOUT_B = 2'd1;
    localparam logic [1:0] LAYOUT_C = 2'd2;

    typedef enum logic [1:0] {
        SLOT_NONE = 2'd0,
        SLOT_B1   = 2'd1,
        SLOT_B2   = 2'd2,
        SLOT_D    = 2'd3
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e         kind;
        logic [POS_W-1:0]   pos;   // 0 = first bit on the wire
    } slot_t;

    function automatic logic [IDX_W-1:0] ix(input int v);
        return IDX_W'(v);
    endfunction

    // Final bit number of each layout.
    function automatic logic [IDX_W-1:0] last_bit(input logic [1:0] layout);
        case (layout)
            LAYOUT_A: return ix(2*B_W + D_W - 1);
            LAYOUT_B: return ix(2*B_W + D_W);
            LAYOUT_C: return ix(3*B_W + D_W - 1);
            default:  return '0;
        endcase
    endfunction

    // Permitted layout and timing pairs.
    function automatic logic combo_ok(input logic [1:0] layout, input logic delayed);
        case (layout)
            LAYOUT_A: return 1'b1;
            LAYOUT_B: return delayed;
            LAYOUT_C: return !delayed;
            default:  return 1'b0;
        endcase
    endfunction

    // Map a frame bit number to the field it carries.
    function automatic slot_t slot_lookup(input logic [1:0] layout,
                                          input logic [IDX_W-1:0] idx,
                                          input logic dport);
        slot_t s;
        logic [IDX_W-1:0] rel;
        s.kind = SLOT_NONE;
        s.pos  = '0;
        rel    = '0;
        case (layout)
            LAYOUT_A: begin
                if (idx < ix(B_W)) begin
                    s.kind = SLOT_B1; s.pos = idx[POS_W-1:0];
                end else if (idx < ix(2*B_W)) begin
                    s.kind = SLOT_B2; s.pos = idx[POS_W-1:0];
                end else if (idx < ix(2*B_W + D_W)) begin
                    s.kind = SLOT_D;  s.pos = idx[POS_W-1:0];
                end
            end
            LAYOUT_B: begin
                if (idx < ix(B_W)) begin
                    s.kind = SLOT_B1; s.pos = idx[POS_W-1:0];
                end else if (idx == ix(B_W)) begin
                    s.kind = SLOT_D;  s.pos = '0;
                end else if (idx >= ix(B_W + 2) && idx < ix(2*B_W + 2)) begin
                    rel    = idx - ix(B_W + 2);
                    s.kind = SLOT_B2; s.pos = rel[POS_W-1:0];
                end else if (idx == ix(2*B_W + 2)) begin
                    s.kind = SLOT_D;  s.pos = POS_W'(1);
                end
            end
            LAYOUT_C: begin
                if (idx < ix(B_W)) begin
                    s.kind = SLOT_B1; s.pos = idx[POS_W-1:0];
                end else if (idx < ix(2*B_W)) begin
                    s.kind = SLOT_B2; s.pos = idx[POS_W-1:0];
                end else if (idx >= ix(3*B_W) && idx < ix(3*B_W + D_W)) begin
                    s.kind = SLOT_D;  s.pos = idx[POS_W-1:0];
                end
            end
            default: s.kind = SLOT_NONE;
        endcase
        if (dport && s.kind == SLOT_D) s.kind = SLOT_NONE;
        return s;
    endfunction

    // Bit of a parallel field that belongs to a slot.
    function automatic logic pick_bit(input slot_t s,
                                      input logic [B_W-1:0] b1,
                                      input logic [B_W-1:0] b2,
                                      input logic [D_W-1:0] d);
        case (s.kind)
            SLOT_B1: return b1[POS_W'(B_W-1) - s.pos];
            SLOT_B2: return b2[POS_W'(B_W-1) - s.pos];
            SLOT_D:  return d[!s.pos[0]];
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/bri_frame_timer.sv
module bri_frame_timer
    import bri_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             delayed,
    input  logic             half,
    input  logic [IDX_W-1:0] last_idx,
    input  logic             fs,
    input  logic             rise,
    input  logic             fall,
    output logic             drv_evt,
    output logic             smp_evt,
    output logic [IDX_W-1:0] idx
);
    localparam int CNT_W = IDX_W + 1;

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic             fs_prev;
        logic             armed;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        logic             start;
        logic [CNT_W-1:0] nxt;
        logic [IDX_W-1:0] nidx;
        s_d     = s_q;
        drv_evt = 1'b0;
        smp_evt = 1'b0;
        idx     = '0;
        start   = 1'b0;
        nxt     = s_q.cnt + CNT_W'(1);
        nidx    = half ? nxt[CNT_W-1:1] : nxt[IDX_W-1:0];

        if (rise) begin
            if (!delayed) begin
                start     = fs && !s_q.fs_prev;
                s_d.fs_prev = fs;
            end else begin
                start     = s_q.armed;
                s_d.armed = 1'b0;
            end
            if (start) begin
                s_d.active = 1'b1;
                s_d.cnt    = '0;
                drv_evt    = 1'b1;
                idx        = '0;
            end else if (s_q.active) begin
                if (nidx > last_idx) begin
                    s_d.active = 1'b0;
                    drv_evt    = 1'b1;
                    idx        = nidx;
                end else begin
                    s_d.cnt = nxt;
                    drv_evt = !half || !nxt[0];
                    idx     = nidx;
                end
            end
        end

        if (fall) begin
            if (delayed) begin
                s_d.armed   = fs && !s_q.fs_prev;
                s_d.fs_prev = fs;
            end
            if (s_q.active) begin
                smp_evt = !half || s_q.cnt[0];
                idx     = half ? s_q.cnt[CNT_W-1:1] : s_q.cnt[IDX_W-1:0];
            end
        end

        if (!en) begin
            s_d.active = 1'b0;
            s_d.armed  = 1'b0;
            drv_evt    = 1'b0;
            smp_evt    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/bri_capture.sv
module bri_capture
    import bri_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_evt,
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] last_idx,
    input  logic [1:0]       layout,
    input  logic             dport,
    input  logic             din,
    output logic [B_W-1:0]   b1,
    output logic [B_W-1:0]   b2,
    output logic [D_W-1:0]   d,
    output logic             valid
);
    typedef struct packed {
        logic [B_W-1:0] acc_b1;
        logic [B_W-1:0] acc_b2;
        logic [D_W-1:0] acc_d;
        logic [B_W-1:0] out_b1;
        logic [B_W-1:0] out_b2;
        logic [D_W-1:0] out_d;
        logic           valid;
    } cap_t;

    cap_t s_d, s_q;

    always_comb begin
        slot_t sl;
        s_d       = s_q;
        s_d.valid = 1'b0;
        sl        = slot_lookup(layout, idx, dport);
        if (smp_evt) begin
            case (sl.kind)
                SLOT_B1: s_d.acc_b1[POS_W'(B_W-1) - sl.pos] = din;
                SLOT_B2: s_d.acc_b2[POS_W'(B_W-1) - sl.pos] = din;
                SLOT_D:  s_d.acc_d[!sl.pos[0]]              = din;
                default: ;
            endcase
            if (idx == last_idx) begin
                s_d.out_b1 = s_d.acc_b1;
                s_d.out_b2 = s_d.acc_b2;
                s_d.out_d  = dport ? '0 : s_d.acc_d;
                s_d.valid  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign b1    = s_q.out_b1;
    assign b2    = s_q.out_b2;
    assign d     = s_q.out_d;
    assign valid = s_q.valid;

endmodule

// File: rtl/bri_drive.sv
module bri_drive
    import bri_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             drv_evt,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       layout,
    input  logic             dport,
    input  logic [B_W-1:0]   src_b1,
    input  logic [B_W-1:0]   src_b2,
    input  logic [D_W-1:0]   src_d,
    output logic             oe,
    output logic             dout
);
    typedef struct packed {
        logic [B_W-1:0] h_b1;
        logic [B_W-1:0] h_b2;
        logic [D_W-1:0] h_d;
        logic           oe;
        logic           bit_v;
    } drv_t;

    drv_t s_d, s_q;

    always_comb begin
        slot_t sl;
        s_d = s_q;
        sl  = slot_lookup(layout, idx, dport);
        if (drv_evt) begin
            if (idx == '0) begin
                s_d.h_b1 = src_b1;
                s_d.h_b2 = src_b2;
                s_d.h_d  = src_d;
            end
            s_d.oe    = (sl.kind != SLOT_NONE);
            s_d.bit_v = pick_bit(sl, s_d.h_b1, s_d.h_b2, s_d.h_d);
        end
        if (!en) begin
            s_d.oe    = 1'b0;
            s_d.bit_v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign oe   = s_q.oe;
    assign dout = s_q.bit_v;

endmodule

// File: rtl/bri_port.sv
module bri_port
    import bri_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sclk,
    input  logic           fs_tx,
    input  logic           fs_rx,
    input  logic           ser_in,
    output logic           ser_out,
    output logic           ser_oe,
    input  logic [1:0]     cfg_layout,
    input  logic           cfg_delayed,
    input  logic           cfg_dport_en,
    input  logic [B_W-1:0] line_rx_b1,
    input  logic [B_W-1:0] line_rx_b2,
    input  logic [D_W-1:0] line_rx_d,
    output logic [B_W-1:0] line_tx_b1,
    output logic [B_W-1:0] line_tx_b2,
    output logic [D_W-1:0] line_tx_d,
    output logic           line_tx_valid,
    output logic           cfg_err
);
    logic             sclk_q;
    logic             rise, fall, half, en;
    logic [IDX_W-1:0] last_idx;
    logic             in_smp, in_drv, out_smp, out_drv;
    logic [IDX_W-1:0] in_idx, out_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    always_comb begin
        rise     = sclk && !sclk_q;
        fall     = !sclk && sclk_q;
        half     = (cfg_layout == LAYOUT_C);
        last_idx = last_bit(cfg_layout);
        en       = combo_ok(cfg_layout, cfg_delayed);
        cfg_err  = !en;
    end

    bri_frame_timer u_in_tmr (
        .clk(clk), .rst_n(rst_n), .en(en), .delayed(cfg_delayed), .half(half),
        .last_idx(last_idx), .fs(fs_tx), .rise(rise), .fall(fall),
        .drv_evt(in_drv), .smp_evt(in_smp), .idx(in_idx)
    );

    bri_frame_timer u_out_tmr (
        .clk(clk), .rst_n(rst_n), .en(en), .delayed(cfg_delayed), .half(half),
        .last_idx(last_idx), .fs(fs_rx), .rise(rise), .fall(fall),
        .drv_evt(out_drv), .smp_evt(out_smp), .idx(out_idx)
    );

    bri_capture u_cap (
        .clk(clk), .rst_n(rst_n), .smp_evt(in_smp), .idx(in_idx),
        .last_idx(last_idx), .layout(cfg_layout), .dport(cfg_dport_en),
        .din(ser_in), .b1(line_tx_b1), .b2(line_tx_b2), .d(line_tx_d),
        .valid(line_tx_valid)
    );

    bri_drive u_drv (
        .clk(clk), .rst_n(rst_n), .en(en), .drv_evt(out_drv), .idx(out_idx),
        .layout(cfg_layout), .dport(cfg_dport_en),
        .src_b1(line_rx_b1), .src_b2(line_rx_b2), .src_d(line_rx_d),
        .oe(ser_oe), .dout(ser_out)
    );

    logic unused_ok;
    assign unused_ok = ^{in_drv, out_smp};

endmodule

// File: rtl/bri_port_chk.sv
module bri_port_chk
    import bri_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           sclk,
    input logic           ser_oe,
    input logic           ser_out,
    input logic           line_tx_valid,
    input logic [D_W-1:0] line_tx_d,
    input logic           cfg_err,
    input logic           cfg_dport_en
);
    a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        line_tx_valid |=> !line_tx_valid);

    a_r9_strobe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_tx_valid) |-> (!$past(sclk) && $past(sclk, 2)));

    a_r6_err_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_err) |-> !ser_oe);

    a_r6_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_err) |-> !line_tx_valid);

    a_r7_oe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_oe) |-> (($past(sclk) && !$past(sclk, 2)) || $past(cfg_err)));

    a_r7_data_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_oe && $past(ser_oe) && !$stable(ser_out)) |-> ($past(sclk) && !$past(sclk, 2)));

    a_r8_dport_no_d: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tx_valid && $past(cfg_dport_en)) |-> (line_tx_d == '0));

endmodule

bind bri_port bri_port_chk u_chk (.*);

// File: tb/sim_bri_port.sv
`timescale 1ns/1ps
module sim_bri_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0, fs_tx = 1'b0, fs_rx = 1'b0, ser_in = 1'b0;
    logic       ser_out, ser_oe;
    logic [1:0] cfg_layout = 2'd0;
    logic       cfg_delayed = 1'b0, cfg_dport_en = 1'b0;
    logic [7:0] line_rx_b1 = '0, line_rx_b2 = '0;
    logic [1:0] line_rx_d = '0;
    logic [7:0] line_tx_b1, line_tx_b2;
    logic [1:0] line_tx_d;
    logic       line_tx_valid, cfg_err;

    int checks = 0, errors = 0, cyc = 0, vcnt = 0;
    logic [7:0] got_b1, got_b2;
    logic [1:0] got_d;

    always #4 clk = ~clk;

    bri_port u0 (.*);

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            summary();
        end
    end

    always @(negedge clk) if (line_tx_valid) begin
        vcnt++; got_b1 = line_tx_b1; got_b2 = line_tx_b2; got_d = line_tx_d;
    end

    // kind: 0 none, 1 B1, 2 B2, 3 D; pos = order on the wire
    task automatic exp_slot(input int lay, input int i, output int kind, output int pos);
        kind = 0; pos = 0;
        if (lay == 0) begin
            if (i < 8) begin kind = 1; pos = i; end
            else if (i < 16) begin kind = 2; pos = i - 8; end
            else if (i < 18) begin kind = 3; pos = i - 16; end
        end else if (lay == 1) begin
            if (i < 8) begin kind = 1; pos = i; end
            else if (i == 8) begin kind = 3; pos = 0; end
            else if (i >= 10 && i < 18) begin kind = 2; pos = i - 10; end
            else if (i == 18) begin kind = 3; pos = 1; end
        end else if (lay == 2) begin
            if (i < 8) begin kind = 1; pos = i; end
            else if (i < 16) begin kind = 2; pos = i - 8; end
            else if (i >= 24 && i < 26) begin kind = 3; pos = i - 24; end
        end
    endtask

    function automatic logic field_bit(int kind, int pos, logic [7:0] b1, logic [7:0] b2, logic [1:0] d);
        if (kind == 1) return b1[7 - pos];
        if (kind == 2) return b2[7 - pos];
        if (kind == 3) return d[1 - pos];
        return 1'b0;
    endfunction

    task automatic run_frame(input int lay, input bit dly, input bit dp,
                             input logic [7:0] ib1, input logic [7:0] ib2, input logic [1:0] id,
                             input logic [7:0] ob1, input logic [7:0] ob2, input logic [1:0] od);
        bit    err  = (lay == 3) || (lay == 1 && !dly) || (lay == 2 && dly);
        bit    half = (lay == 2);
        int    last = (lay == 0) ? 17 : (lay == 1) ? 18 : (lay == 2) ? 25 : 17;
        int    nr   = (last + 1) * (half ? 2 : 1) + 3;
        string tag  = err ? "R6" : (lay == 0) ? "R1" : (lay == 1) ? "R2" : "R3";
        cfg_layout = lay[1:0]; cfg_delayed = dly; cfg_dport_en = dp;
        line_rx_b1 = ob1; line_rx_b2 = ob2; line_rx_d = od;
        repeat (4) @(negedge clk);
        chk(cfg_err == err, "R6 legality flag", cfg_err, err);
        vcnt = 0;
        if (dly) begin  // R5: sync seen at the falling edge before bit 0
            sclk = 1'b1; fs_tx = 1'b1; fs_rx = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
            repeat (4) @(negedge clk);
        end
        for (int k = 0; k < nr; k++) begin
            int    i = half ? k / 2 : k;
            int    kind, pos;
            bit    eo;
            logic  eb;
            string rq;
            exp_slot(lay, i, kind, pos);
            sclk = 1'b1;
            if (k == 0) begin fs_tx = !dly; fs_rx = !dly; end
            if (k == 1) begin fs_tx = 1'b0; fs_rx = 1'b0; end
            ser_in = (kind != 0) ? field_bit(kind, pos, ib1, ib2, id) : k[0];
            if (k == 1) begin  // R10: late change must not reach this frame
                line_rx_b1 = ~ob1; line_rx_b2 = ~ob2; line_rx_d = ~od;
            end
            repeat (2) @(negedge clk);
            eo = !err && kind != 0 && !(kind == 3 && dp);
            eb = eo ? field_bit(kind, pos, ob1, ob2, od) : 1'b0;
            if (err) rq = "R6";
            else if (k == 0) rq = dly ? "R5 first bit" : "R4 first bit";
            else if (kind == 3 && dp) rq = "R8 D removed";
            else if (kind == 0) rq = "R7 unassigned";
            else if (kind == 2) rq = {tag, " R10 B2 held"};
            else rq = tag;
            chk(ser_oe == eo, {rq, " oe"}, ser_oe, eo);
            if (eo) chk(ser_out == eb, {rq, " data"}, ser_out, eb);
            repeat (2) @(negedge clk);
            sclk = 1'b0;
            repeat (4) @(negedge clk);
        end
        repeat (2) @(negedge clk);
        chk(vcnt == (err ? 0 : 1), "R9 strobe count", vcnt, err ? 0 : 1);
        if (!err) begin
            chk(got_b1 == ib1, {tag, " capture B1"}, got_b1, ib1);
            chk(got_b2 == ib2, {tag, " capture B2"}, got_b2, ib2);
            chk(got_d == (dp ? 2'b00 : id), dp ? "R8 capture D" : {tag, " capture D"},
                got_d, dp ? 0 : id);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ser_oe == 1'b0, "R11 reset oe", ser_oe, 0);
        chk(ser_out == 1'b0, "R11 reset out", ser_out, 0);
        chk(line_tx_valid == 1'b0, "R11 reset strobe", line_tx_valid, 0);
        chk({line_tx_b1, line_tx_b2, line_tx_d} == '0, "R11 reset fields", line_tx_b1, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        run_frame(0, 1'b0, 1'b0, 8'hA5, 8'h3C, 2'b10, 8'h96, 8'h1E, 2'b01);
        run_frame(0, 1'b1, 1'b1, 8'h5A, 8'hC3, 2'b11, 8'hF0, 8'h0F, 2'b11);
        run_frame(1, 1'b1, 1'b0, 8'h81, 8'h7E, 2'b01, 8'hC5, 8'h6A, 2'b10);
        run_frame(1, 1'b1, 1'b1, 8'h12, 8'h34, 2'b10, 8'h56, 8'h78, 2'b01);
        run_frame(2, 1'b0, 1'b0, 8'hE7, 8'h18, 2'b01, 8'h2D, 8'hB4, 2'b10);
        run_frame(1, 1'b0, 1'b0, 8'hFF, 8'hFF, 2'b11, 8'hFF, 8'hFF, 2'b11);
        run_frame(2, 1'b1, 1'b0, 8'hFF, 8'hFF, 2'b11, 8'hFF, 8'hFF, 2'b11);
        run_frame(3, 1'b0, 1'b0, 8'hFF, 8'hFF, 2'b11, 8'hFF, 8'hFF, 2'b11);
        run_frame(0, 1'b1, 1'b0, 8'h69, 8'h0F, 2'b01, 8'h33, 8'hCC, 2'b10);
        summary();
    end

endmodule